// File: doc/BRIEF.md
# Repeat-Interval Down-Counter Timer Channel

A single programmable timer channel built around a 24-bit down-counter. Software programs an interval through a small synchronous register port; writing that register is also how the channel is started and stopped. A non-zero interval written to an idle channel starts it at once, with the counter loaded to the interval minus one and decremented once per clock. When the counter reaches zero the interval ends: a sticky interrupt flag is raised and, depending on the mode, the channel either reloads and runs again (repeat) or goes idle (one-shot).

A write-only force bit in the interval register selects how a write to a running channel takes effect. With force set, the new value (or a stop, for zero) applies on the next clock. With force clear, the counter is left alone and the written value is used only when the current interval ends. Software can read back the stored interval, the mode, the live count and a status word.

The register port has four word addresses: 0 interval, 1 control, 2 count (read-only), 3 status. Reads are registered: `rd_data` shows the addressed register one clock after `rd_en`, holding the value sampled at that edge.

Top module: `tmr_channel`

## Requirements
- R1: After reset every register reads 0, `irq` is low and the channel is idle.
- R2: In the interval register (address 0), bits 23:0 hold the interval and bit 31 is the force bit; bits 30:24 are ignored, and a read of address 0 returns the interval in bits 23:0 with bits 31:24 as 0.
- R3: A non-zero interval written to an idle channel starts it: the next clock the count (address 2) reads interval minus 1 and status bit 1 (running) is 1.
- R4: While running the count decreases by one per clock; when it is 0 the interval ends on that clock and the interrupt flag (status bit 0, also driven on `irq`) is set.
- R5: In repeat mode (control bit 0 = 1) an ending interval reloads the count with the most recently written interval minus 1; a write with force clear made during the interval is used only at this reload.
- R6: In one-shot mode (control bit 0 = 0) an ending interval makes the channel idle: running reads 0 and the count reads 0, as it does whenever the channel is idle.
- R7: A non-zero interval written with force set to a running channel loads interval minus 1 into the count on the next clock.
- R8: Zero written with force set to a running channel stops it on the next clock, without an interrupt.
- R9: Zero written with force clear to a running channel lets the current interval finish, then stops the channel and sets the interrupt flag.
- R10: The interrupt flag stays set until 1 is written to status bit 0; writing 0 there has no effect, and an interval ending on the same clock as the clearing write leaves the flag set.
- R11: Zero written to an idle channel leaves it idle with count 0.
- R12: An interval of 1 in repeat mode ends an interval on every clock; the channel stays running with count 0.
- R13: An interval write on the clock where an interval ends takes priority over the automatic reload: in repeat mode the new value minus 1 is loaded, and a forced non-zero write keeps even a one-shot channel running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address: 0 interval, 1 control, 2 count, 3 status |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The properties assume that after reset release the write strobe, address and write data carry defined values and that at most one register access occurs per clock, so a write decoded as an interval write is the only source of a forced load or stop that cycle. The bench drives every input from a falling edge with known values, performs a single read or write per clock and waits out the internal reset synchronizer before its first access. Scenarios land writes on exactly the clock where an interval ends, so the priority and set-versus-clear corners are reached by cycle counting rather than by chance.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_IVAL  = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_STAT  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_RPT_BIT = 0;
  localparam int unsigned STAT_IRQ_BIT = 0;
  localparam int unsigned STAT_RUN_BIT = 1;

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  ival,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              run,
  input  logic              irq,
  output logic              ival_wr,
  output logic [CNT_W-1:0]  ival_data,
  output logic              ival_force,
  output logic              irq_clr,
  output logic              rpt,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned PAD_W   = DATA_W - CNT_W;
  localparam int unsigned FORCE_B = DATA_W - 1;

  logic              rpt_q, rpt_d, rpt_en;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic [DATA_W-1:0] stat_word, ctrl_word;

  // write decode
  always_comb begin
    ival_wr    = wr_en && (addr == SEL_IVAL);
    ival_data  = wr_data[CNT_W-1:0];
    ival_force = wr_data[FORCE_B];
    irq_clr    = wr_en && (addr == SEL_STAT) && wr_data[STAT_IRQ_BIT];
    rpt_en     = wr_en && (addr == SEL_CTRL);
    rpt_d      = wr_data[CTRL_RPT_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_q <= 1'b0;
    end else if (rpt_en) begin
      rpt_q <= rpt_d;
    end
  end

  assign rpt = rpt_q;

  // read mux; the force bit has no storage so it reads as zero
  always_comb begin
    stat_word               = '0;
    stat_word[STAT_IRQ_BIT] = irq;
    stat_word[STAT_RUN_BIT] = run;
    ctrl_word               = '0;
    ctrl_word[CTRL_RPT_BIT] = rpt_q;
    unique case (addr)
      SEL_IVAL:  rd_d = {{PAD_W{1'b0}}, ival};
      SEL_CTRL:  rd_d = ctrl_word;
      SEL_COUNT: rd_d = {{PAD_W{1'b0}}, cnt};
      default:   rd_d = stat_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_wr,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             ld_force,
  input  logic             rpt,
  output logic [CNT_W-1:0] ival,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] ival_q, ival_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic [CNT_W-1:0] next_ival;
  logic             direct_ld;
  logic             end_now;

  always_comb begin
    end_now   = run_q && (cnt_q == '0);
    next_ival = ld_wr ? ld_val : ival_q;
    direct_ld = ld_wr && (ld_force || !run_q);
    ival_d    = ld_val;
    cnt_d     = cnt_q;
    run_d     = run_q;
    if (direct_ld) begin
      if (ld_val != '0) begin
        run_d = 1'b1;
        cnt_d = ld_val - ONE;
      end else begin
        run_d = 1'b0;
        cnt_d = '0;
      end
    end else if (end_now) begin
      if (rpt && (next_ival != '0)) begin
        cnt_d = next_ival - ONE;
      end else begin
        run_d = 1'b0;
        cnt_d = '0;
      end
    end else if (run_q) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ival_q <= '0;
    end else if (ld_wr) begin
      ival_q <= ival_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign ival   = ival_q;
  assign cnt    = cnt_q;
  assign run    = run_q;
  assign expire = end_now;

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  logic flag_q, flag_d;

  // a set on the same clock as a clear wins
  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  logic             rst_n;
  logic             ival_wr, ival_force, irq_clr, rpt_w;
  logic [CNT_W-1:0] ival_data, ival_w, cnt_w;
  logic             run_w, expire_w, irq_w;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_n_sync (rst_n)
  );

  tmr_regif #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .ival       (ival_w),
    .cnt        (cnt_w),
    .run        (run_w),
    .irq        (irq_w),
    .ival_wr    (ival_wr),
    .ival_data  (ival_data),
    .ival_force (ival_force),
    .irq_clr    (irq_clr),
    .rpt        (rpt_w),
    .rd_data    (rd_data)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_wr    (ival_wr),
    .ld_val   (ival_data),
    .ld_force (ival_force),
    .rpt      (rpt_w),
    .ival     (ival_w),
    .cnt      (cnt_w),
    .run      (run_w),
    .expire   (expire_w)
  );

  tmr_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (expire_w),
    .clr   (irq_clr),
    .flag  (irq_w)
  );

  assign irq = irq_w;

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq,
  input logic              run,
  input logic [CNT_W-1:0]  cnt,
  input logic              rpt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic iv_wr, iv_force, iv_zero, st_clr;
  assign iv_wr    = wr_en && (addr == 2'd0);
  assign iv_force = wr_data[DATA_W-1];
  assign iv_zero  = (wr_data[CNT_W-1:0] == '0);
  assign st_clr   = wr_en && (addr == 2'd3) && wr_data[0];

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && iv_wr && !iv_zero) |=> (run && cnt == $past(wr_data[CNT_W-1:0]) - ONE));

  assert_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != '0 && !(iv_wr && iv_force)) |=> (run && cnt == $past(cnt) - ONE));

  assert_irq_on_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == '0) |=> irq);

  assert_oneshot_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == '0 && !rpt && !(iv_wr && iv_force)) |=> !run);

  assert_idle_count_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> cnt == '0);

  assert_force_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && iv_wr && iv_force && iv_zero) |=> !run);

  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !st_clr) |=> irq);

endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wr_data (wr_data),
  .irq     (irq),
  .run     (run_w),
  .cnt     (cnt_w),
  .rpt     (rpt_w)
);

// File: tb/tmr_channel_bench.sv
module tmr_channel_bench;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        wr_en, rd_en;
  logic [1:0]  addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        irq;
  int          n_chk  = 0;
  int          n_fail = 0;

  localparam logic [1:0] A_IVAL = 2'd0, A_CTRL = 2'd1, A_CNT = 2'd2, A_STAT = 2'd3;
  localparam logic [31:0] FORCE = 32'h8000_0000;

  always #5 clk = ~clk;

  tmr_channel u_tmr_channel (
    .clk(clk), .arst_n(arst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // every access takes exactly one clock, starting and ending at a falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic nop();
    @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset();
    chk("R1 irq", {31'b0, irq}, 32'd0);
    rd_chk("R1 ival", A_IVAL, 0);
    rd_chk("R1 ctrl", A_CTRL, 0);
    rd_chk("R1 count", A_CNT, 0);
    rd_chk("R1 stat", A_STAT, 0);
  endtask

  task automatic t_idle_zero();
    wr(A_IVAL, 32'd0);
    rd_chk("R11 stat", A_STAT, 0);
    rd_chk("R11 count", A_CNT, 0);
  endtask

  task automatic t_oneshot();
    wr(A_IVAL, 32'd5);
    rd_chk("R3 first count", A_CNT, 4);
    rd_chk("R4 count", A_CNT, 3);
    rd_chk("R4 count", A_CNT, 2);
    rd_chk("R4 count", A_CNT, 1);
    rd_chk("R4 count zero", A_CNT, 0);
    rd_chk("R6 stat idle irq", A_STAT, 32'd1);
    chk("R4 irq pin", {31'b0, irq}, 32'd1);
    rd_chk("R6 idle count", A_CNT, 0);
    rd_chk("R2 ival read", A_IVAL, 5);
    wr(A_STAT, 32'd0);
    rd_chk("R10 zero write keeps flag", A_STAT, 32'd1);
    wr(A_STAT, 32'd1);
    rd_chk("R10 cleared", A_STAT, 0);
    chk("R10 irq pin", {31'b0, irq}, 32'd0);
    wr(A_IVAL, 32'hFF00_0003);
    rd_chk("R2 upper bits dropped", A_IVAL, 32'd3);
    wr(A_IVAL, FORCE);
    rd_chk("R8 stopped no irq", A_STAT, 0);
  endtask

  task automatic t_repeat();
    wr(A_CTRL, 32'd1);
    rd_chk("R5 ctrl", A_CTRL, 32'd1);
    wr(A_IVAL, 32'd3);
    rd_chk("R5 count", A_CNT, 2);
    rd_chk("R5 count", A_CNT, 1);
    rd_chk("R5 count", A_CNT, 0);
    rd_chk("R5 reload", A_CNT, 2);
    wr(A_IVAL, 32'd6);
    rd_chk("R5 deferred keeps count", A_CNT, 0);
    rd_chk("R5 new interval at reload", A_CNT, 5);
    rd_chk("R5 ival", A_IVAL, 6);
    wr(A_IVAL, FORCE);
    wr(A_STAT, 32'd1);
    rd_chk("R5 stopped", A_STAT, 0);
  endtask

  task automatic t_force();
    wr(A_IVAL, 32'd10);
    rd_chk("R7 start", A_CNT, 9);
    wr(A_IVAL, FORCE | 32'd4);
    rd_chk("R7 forced load", A_CNT, 3);
    wr(A_IVAL, FORCE);
    rd_chk("R8 stat", A_STAT, 0);
    rd_chk("R8 count", A_CNT, 0);
  endtask

  task automatic t_defer_stop();
    wr(A_IVAL, 32'd3);
    wr(A_IVAL, 32'd0);
    rd_chk("R9 still running", A_STAT, 32'd2);
    rd_chk("R9 count", A_CNT, 0);
    rd_chk("R9 stopped with irq", A_STAT, 32'd1);
    wr(A_STAT, 32'd1);
  endtask

  task automatic t_unit();
    wr(A_IVAL, 32'd1);
    wr(A_STAT, 32'd1);
    rd_chk("R10 set beats clear", A_STAT, 32'd3);
    rd_chk("R12 count", A_CNT, 0);
    chk("R12 irq pin", {31'b0, irq}, 32'd1);
    wr(A_IVAL, FORCE);
    wr(A_STAT, 32'd1);
    rd_chk("R12 stopped", A_STAT, 0);
  endtask

  task automatic t_collide();
    wr(A_IVAL, 32'd2);
    nop();
    wr(A_IVAL, 32'd5);
    rd_chk("R13 write beats reload", A_CNT, 4);
    wr(A_IVAL, FORCE);
    wr(A_STAT, 32'd1);
    wr(A_CTRL, 32'd0);
    wr(A_IVAL, 32'd2);
    nop();
    wr(A_IVAL, FORCE | 32'd3);
    rd_chk("R13 forced at one-shot end", A_CNT, 2);
    rd_chk("R13 stat", A_STAT, 32'd3);
    wr(A_IVAL, FORCE);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    arst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_idle_zero();
    t_oneshot();
    t_repeat();
    t_force();
    t_defer_stop();
    t_unit();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule